// File: doc/BRIEF.md
# Serial Command Front End with Pause

This block sits between a four-wire serial host link and the register controller of a two-channel register device. It samples the host's select, clock, data and pause lines with the system clock, in SPI mode 0 style. It checks that each frame is addressed to this device and cuts the frame into bytes. It then hands the controller a decoded instruction and each following data byte as single-cycle strobes. Read data from the controller is shifted back to the host on the serial output. The output-enable signal tells the pad when to drive the line.

A frame opens with an addressing byte. Its upper nibble is a fixed device-type code and its lower nibble must match the board strap inputs; any other value makes the device sit out the rest of the frame. The second byte is the instruction. Every byte after that is data. A pause input lets the host freeze a frame part-way through and later continue it exactly where it stopped. What the opcodes mean and the register storage belong to the controller, not to this block.

Top module: `spi_cmd_frontend`

## Requirements
- R1: The serial input is taken on each rising serial-clock edge, most significant bit first. The eighth bit of every byte after the instruction yields `wr_data` with a one-cycle `wr_valid` pulse.
- R2: The serial output changes only after a falling serial-clock edge. During each data byte it carries, MSB first, the `rd_data` value sampled in the cycle of the strobe that closed the previous byte (`instr_valid` or `wr_valid`).
- R3: While `csn` is high, `so_oe` is low. Raising `csn` part-way through a frame discards it, and the next frame decodes from its first bit.
- R4: The first byte of a frame is accepted only if bits [7:4] equal 4'b0101 and bits [3:0] equal `strap_addr`. Otherwise the frame gives no strobe and `so_oe` stays low until `csn` rises.
- R5: The second byte yields a one-cycle `instr_valid` pulse with `opcode` = bits [7:4], `reg_ptr` = bits [3:2] and `chan_sel` = bit 0. Bit 1 is reserved.
- R6: A falling `holdn` while the serial clock is low pauses the frame. A rising `holdn` while the serial clock is low resumes it. Bit position, shifted bits and pending read bits are kept across the pause.
- R7: While paused, serial-clock edges neither shift data in nor shift data out, and `so_oe` is low.
- R8: A `holdn` edge that occurs while the serial clock is high does not pause the frame.
- R9: After reset, no frame is accepted until a high-to-low transition of `csn` has been seen.
- R10: After reset, `so_oe`, `instr_valid`, `wr_valid`, `opcode`, `reg_ptr`, `chan_sel` and `wr_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| holdn | input | 1 | Pause request, active low |
| strap_addr | input | ADDR_W | Board-strapped device address |
| rd_data | input | BYTE_W | Byte the controller offers for shifting out |
| so_data | output | 1 | Serial output data bit |
| so_oe | output | 1 | Drive enable for the serial output pad |
| opcode | output | BYTE_W-4 | Opcode of the last accepted instruction |
| reg_ptr | output | 2 | Data register pointer of the last instruction |
| chan_sel | output | 1 | Channel select of the last instruction |
| instr_valid | output | 1 | One-cycle strobe: instruction fields updated |
| wr_data | output | BYTE_W | Last received data byte |
| wr_valid | output | 1 | One-cycle strobe: data byte received |

## Verification
Shifting data in on the rising edge and shifting read bits out on the falling edge both run during every data byte. The bench checks that each byte in both directions comes out intact when the host pauses in the middle of a data byte, with serial-clock pulses sent during the pause. The other overlap is a pause edge that arrives while the serial clock is high. The bench makes `holdn` fall in the high half of a bit, keeps clocking, and checks that every bit of the instruction still lands and decodes.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  // frame position of the byte currently being shifted
  typedef enum logic [1:0] {
    PH_ID     = 2'd0,
    PH_INSTR  = 2'd1,
    PH_DATA   = 2'd2,
    PH_IGNORE = 2'd3
  } phase_t;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned     W       = 4,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst,
  input  logic csn_s,
  input  logic sck_s,
  input  logic holdn_s,
  output logic paused
);

  logic holdn_d;
  logic hold_fall;
  logic hold_rise;

  assign hold_fall = holdn_d & ~holdn_s;
  assign hold_rise = ~holdn_d & holdn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdn_d <= 1'b1;
      paused  <= 1'b0;
    end else begin
      holdn_d <= holdn_s;
      if (csn_s)
        paused <= 1'b0;
      else if (hold_fall && !sck_s)
        paused <= 1'b1;
      else if (hold_rise && !sck_s)
        paused <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_fe_frame.sv
module spi_fe_frame
  import spi_fe_pkg::*;
#(
  parameter int unsigned           BYTE_W   = 8,
  parameter int unsigned           ADDR_W   = 4,
  parameter int unsigned           TYPE_W   = BYTE_W - ADDR_W,
  parameter logic [TYPE_W-1:0]     DEV_TYPE = 4'b0101
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csn_s,
  input  logic                si_s,
  input  logic                sck_rise,
  input  logic                paused,
  input  logic [ADDR_W-1:0]   strap_addr,
  output logic                active,
  output phase_t              phase,
  output logic [BYTE_W-5:0]   opcode,
  output logic [1:0]          reg_ptr,
  output logic                chan_sel,
  output logic                instr_valid,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                wr_valid,
  output logic                tx_load
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              csn_d;
  logic              armed;
  logic              cs_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt;
  logic              take_bit;
  logic              id_ok;

  assign cs_fall  = csn_d & ~csn_s;
  assign active   = armed & ~csn_s;
  assign nxt      = {shreg[BYTE_W-2:0], si_s};
  assign take_bit = active & sck_rise & ~paused & (phase != PH_IGNORE);
  assign id_ok    = (nxt[BYTE_W-1 -: TYPE_W] == DEV_TYPE) &&
                    (nxt[ADDR_W-1:0] == strap_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_d       <= 1'b0;
      armed       <= 1'b0;
      phase       <= PH_ID;
      bit_cnt     <= '0;
      shreg       <= '0;
      opcode      <= '0;
      reg_ptr     <= '0;
      chan_sel    <= 1'b0;
      instr_valid <= 1'b0;
      wr_data     <= '0;
      wr_valid    <= 1'b0;
      tx_load     <= 1'b0;
    end else begin
      csn_d       <= csn_s;
      instr_valid <= 1'b0;
      wr_valid    <= 1'b0;
      tx_load     <= 1'b0;
      if (cs_fall) armed <= 1'b1;
      if (csn_s || cs_fall) begin
        phase   <= PH_ID;
        bit_cnt <= '0;
      end else if (take_bit) begin
        shreg   <= nxt;
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == LAST_BIT) begin
          unique case (phase)
            PH_ID: phase <= id_ok ? PH_INSTR : PH_IGNORE;
            PH_INSTR: begin
              opcode      <= nxt[BYTE_W-1:4];
              reg_ptr     <= nxt[3:2];
              chan_sel    <= nxt[0];
              instr_valid <= 1'b1;
              tx_load     <= 1'b1;
              phase       <= PH_DATA;
            end
            PH_DATA: begin
              wr_data  <= nxt;
              wr_valid <= 1'b1;
              tx_load  <= 1'b1;
            end
            default: phase <= PH_IGNORE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_fe_sodrv.sv
module spi_fe_sodrv #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              sck_fall,
  input  logic              shift_en,
  input  logic              oe_en,
  output logic              so_data,
  output logic              so_oe
);

  logic [BYTE_W-1:0] tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx      <= '0;
      so_data <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      so_oe <= oe_en;
      if (load)
        tx <= rd_data;
      else if (sck_fall && shift_en) begin
        so_data <= tx[BYTE_W-1];
        tx      <= {tx[BYTE_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int unsigned       BYTE_W      = 8,
  parameter int unsigned       ADDR_W      = 4,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [3:0]        DEV_TYPE    = 4'b0101
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csn,
  input  logic                sck,
  input  logic                si,
  input  logic                holdn,
  input  logic [ADDR_W-1:0]   strap_addr,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                so_data,
  output logic                so_oe,
  output logic [BYTE_W-5:0]   opcode,
  output logic [1:0]          reg_ptr,
  output logic                chan_sel,
  output logic                instr_valid,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                wr_valid
);

  localparam int unsigned TYPE_W = BYTE_W - ADDR_W;
  // bit order of the synchronised bundle: {holdn, csn, sck, si}
  localparam logic [3:0]  SYNC_RST = 4'b1000;

  logic [3:0] raw_in;
  logic [3:0] sync_out;
  logic       si_s, sck_s, csn_s, holdn_s;
  logic       sck_d;
  logic       sck_rise, sck_fall;
  logic       paused;
  logic       active;
  phase_t     phase;
  logic       tx_load;
  logic       in_data;

  assign raw_in = {holdn, csn, sck, si};

  spi_fe_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw_in),
    .d_out (sync_out)
  );

  assign {holdn_s, csn_s, sck_s, si_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  spi_fe_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .csn_s   (csn_s),
    .sck_s   (sck_s),
    .holdn_s (holdn_s),
    .paused  (paused)
  );

  spi_fe_frame #(
    .BYTE_W   (BYTE_W),
    .ADDR_W   (ADDR_W),
    .TYPE_W   (TYPE_W),
    .DEV_TYPE (DEV_TYPE[TYPE_W-1:0])
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .csn_s       (csn_s),
    .si_s        (si_s),
    .sck_rise    (sck_rise),
    .paused      (paused),
    .strap_addr  (strap_addr),
    .active      (active),
    .phase       (phase),
    .opcode      (opcode),
    .reg_ptr     (reg_ptr),
    .chan_sel    (chan_sel),
    .instr_valid (instr_valid),
    .wr_data     (wr_data),
    .wr_valid    (wr_valid),
    .tx_load     (tx_load)
  );

  assign in_data = active & ~paused & (phase == PH_DATA);

  spi_fe_sodrv #(
    .BYTE_W (BYTE_W)
  ) u_sodrv (
    .clk      (clk),
    .rst      (rst),
    .load     (tx_load),
    .rd_data  (rd_data),
    .sck_fall (sck_fall),
    .shift_en (in_data),
    .oe_en    (in_data),
    .so_data  (so_data),
    .so_oe    (so_oe)
  );

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
  import spi_fe_pkg::*;
#(
  parameter int unsigned OP_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            csn_s,
  input logic            paused,
  input phase_t          phase,
  input logic            sck_fall,
  input logic            so_data,
  input logic            so_oe,
  input logic            instr_valid,
  input logic            wr_valid,
  input logic [OP_W-1:0] opcode,
  input logic [1:0]      reg_ptr,
  input logic            chan_sel
);

  assert_oe_off_deselect_R3: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !so_oe);

  assert_oe_off_paused_R7: assert property (@(posedge clk) disable iff (rst)
    paused |=> !so_oe);

  assert_so_moves_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(so_data) |-> $past(sck_fall));

  assert_no_strobe_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGNORE) |-> (!instr_valid && !wr_valid));

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> ($stable(opcode) && $stable(reg_ptr) && $stable(chan_sel)));

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({instr_valid, wr_valid}));

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(.OP_W(BYTE_W - 4)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csn_s       (csn_s),
  .paused      (paused),
  .phase       (phase),
  .sck_fall    (sck_fall),
  .so_data     (so_data),
  .so_oe       (so_oe),
  .instr_valid (instr_valid),
  .wr_valid    (wr_valid),
  .opcode      (opcode),
  .reg_ptr     (reg_ptr),
  .chan_sel    (chan_sel)
);

// File: tb/tb_spi_cmd_frontend.sv
`timescale 1ns/1ps
module tb_spi_cmd_frontend;

  logic       clk = 1'b0;
  logic       rst, csn, sck, si, holdn;
  logic [3:0] strap_addr;
  logic [7:0] rd_data;
  logic       so_data, so_oe, chan_sel, instr_valid, wr_valid;
  logic [3:0] opcode;
  logic [1:0] reg_ptr;
  logic [7:0] wr_data;

  int ntot = 0, nfail = 0;
  int icnt = 0, wcnt = 0;
  bit oe_seen = 0;
  bit cap = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  spi_cmd_frontend dut (
    .clk(clk), .rst(rst), .csn(csn), .sck(sck), .si(si), .holdn(holdn),
    .strap_addr(strap_addr), .rd_data(rd_data), .so_data(so_data),
    .so_oe(so_oe), .opcode(opcode), .reg_ptr(reg_ptr), .chan_sel(chan_sel),
    .instr_valid(instr_valid), .wr_data(wr_data), .wr_valid(wr_valid)
  );

  always @(posedge clk) begin
    if (instr_valid) icnt++;
    if (wr_valid)    wcnt++;
    if (so_oe)       oe_seen = 1;
  end

  // {strap, id byte, instr byte, data byte, read byte, accepted}
  localparam logic [36:0] VEC [6] = '{
    {4'hA, 8'h5A, 8'h3D, 8'hC3, 8'h96, 1'b1},
    {4'hA, 8'h6A, 8'h3D, 8'hC3, 8'h96, 1'b0},
    {4'h3, 8'h53, 8'hA0, 8'h01, 8'h80, 1'b1},
    {4'h3, 8'h5B, 8'hA0, 8'h01, 8'h80, 1'b0},
    {4'hF, 8'h5F, 8'h56, 8'hFF, 8'h00, 1'b1},
    {4'h0, 8'h50, 8'hF5, 8'h5A, 8'hA5, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    si = b;
    #40;
    if (cap) got = {got[6:0], so_data};
    sck = 1'b1;
    #40;
    sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
  endtask

  task automatic pulse_sck(input int n);
    for (int i = 0; i < n; i++) begin
      si = 1'b1; #40; sck = 1'b1; #40; sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    csn = 1'b0; #40;
    sbyte(b0); sbyte(b1);
    cap = 1; sbyte(b2); cap = 0;
    #40; csn = 1'b1; #80;
  endtask

  initial begin
    #1000000;
    nfail++; ntot++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    int i0, w0;
    rst = 1; csn = 0; sck = 0; si = 0; holdn = 1; strap_addr = 4'hA; rd_data = 8'h00;
    #50; rst = 0; #20;

    // R10 reset state
    chk(so_oe == 0 && instr_valid == 0 && wr_valid == 0, "R10 strobes/oe", {so_oe, instr_valid, wr_valid}, 0);
    chk(opcode == 0 && reg_ptr == 0 && chan_sel == 0 && wr_data == 0, "R10 fields",
        {opcode, reg_ptr, chan_sel, wr_data}, 0);

    // R9: select already low since reset, no falling edge seen
    rd_data = 8'h96;
    sbyte(8'h5A); sbyte(8'h3D); sbyte(8'hC3); #80;
    chk(icnt == 0 && wcnt == 0, "R9 no strobes before select fall", {icnt, wcnt}, 0);
    chk(oe_seen == 0, "R9 oe stays low", oe_seen, 0);
    csn = 1; #80;

    // table of frames
    foreach (VEC[k]) begin
      logic [36:0] v;
      v = VEC[k];
      strap_addr = v[36:33]; rd_data = v[8:1];
      i0 = icnt; w0 = wcnt; oe_seen = 0;
      frame(v[32:25], v[24:17], v[16:9]);
      chk(icnt - i0 == int'(v[0]), "R4/R5 instr strobe count", icnt - i0, v[0]);
      chk(wcnt - w0 == int'(v[0]), "R4/R1 data strobe count", wcnt - w0, v[0]);
      chk(so_oe == 0, "R3 oe low after deselect", so_oe, 0);
      if (v[0]) begin
        chk({opcode, reg_ptr, chan_sel} == {v[24:21], v[20:19], v[17]}, "R5 instr fields",
            {opcode, reg_ptr, chan_sel}, {v[24:21], v[20:19], v[17]});
        chk(wr_data == v[16:9], "R1 data byte", wr_data, v[16:9]);
        chk(got == v[8:1], "R2 read byte on SO", got, v[8:1]);
      end else begin
        chk(oe_seen == 0, "R4 oe stays low on mismatch", oe_seen, 0);
      end
    end

    // R6/R7: pause inside instruction and inside data byte
    strap_addr = 4'hA; rd_data = 8'h5C; i0 = icnt;
    csn = 0; #40;
    sbyte(8'h5A);
    sbit(0); sbit(1); sbit(1); sbit(1);
    holdn = 0; #40; pulse_sck(3); holdn = 1; #40;
    sbit(1); sbit(1); sbit(0); sbit(0);
    cap = 1;
    sbit(0); sbit(0); sbit(1);
    holdn = 0; #80;
    chk(so_oe == 0, "R7 oe low while paused", so_oe, 0);
    pulse_sck(2);
    holdn = 1; #80;
    chk(so_oe == 1, "R6 oe back after resume", so_oe, 1);
    sbit(1); sbit(1); sbit(1); sbit(0); sbit(0);
    cap = 0;
    #40; csn = 1; #80;
    chk(icnt - i0 == 1 && {opcode, reg_ptr, chan_sel} == 7'b0111_11_0, "R6 instr across pause",
        {opcode, reg_ptr, chan_sel}, 7'b0111_11_0);
    chk(wr_data == 8'h3C, "R7 data across pause", wr_data, 8'h3C);
    chk(got == 8'h5C, "R6 read byte across pause", got, 8'h5C);

    // R8: pause edge during high clock phase is ignored
    i0 = icnt; rd_data = 8'h00;
    csn = 0; #40;
    sbyte(8'h5A);
    si = 1; #40; sck = 1; #20; holdn = 0; #20; sck = 0;
    sbit(0); sbit(0); sbit(1); sbit(0); sbit(1); sbit(1); sbit(0);
    holdn = 1; #40;
    sbyte(8'h11);
    #40; csn = 1; #80;
    chk(icnt - i0 == 1 && {opcode, reg_ptr, chan_sel} == 7'b1001_01_0, "R8 high-phase pause ignored",
        {opcode, reg_ptr, chan_sel}, 7'b1001_01_0);
    chk(wr_data == 8'h11, "R8 data after ignored pause", wr_data, 8'h11);

    // R3: abort mid-instruction, then a clean frame
    i0 = icnt;
    csn = 0; #40;
    sbyte(8'h5A); sbit(1); sbit(1); sbit(1); sbit(1);
    csn = 1; #80;
    chk(so_oe == 0 && icnt == i0, "R3 abort gives nothing", icnt - i0, 0);
    frame(8'h5A, 8'h21, 8'h44);
    chk(icnt - i0 == 1 && {opcode, reg_ptr, chan_sel} == 7'b0010_00_1, "R3 clean frame after abort",
        {opcode, reg_ptr, chan_sel}, 7'b0010_00_1);

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

endmodule